// File: doc/BRIEF.md
# Ethernet Descriptor Ring Controller

This block keeps the buffer descriptor table of an Ethernet MAC. It also holds the transmit and receive ring pointers and the interrupt pending and enable registers. A host programs descriptors and registers over a plain 32-bit register bus. One table of `NUM_BD` two-word entries is shared by both directions. A programmable count splits it: the first entries form the transmit ring and the remaining entries form the receive ring.

On the transmit side, the descriptor under the transmit pointer is offered to the MAC once the host sets its ownership bit. The offer carries the buffer address, the length, the pad request and the FCS request. When the MAC reports completion, the block writes the completion status back into the descriptor, hands ownership back and moves to the next descriptor. On the receive side, a frame-done event with a length and error flags is written into the current descriptor if the host has marked that descriptor as free. Otherwise the frame is dropped and a busy flag is raised. Both directions set write-one-to-clear pending bits, and a single interrupt line combines them with the enable bits.

Top module: `eth_bd_ring`

## Requirements
- R1: After reset, every descriptor word, the pending register, the enable register and the transmit count read 0. Both ring pointers sit at index 0, and `tx_req_valid` and `irq` are low.
- R2: Word w of descriptor i is mapped at byte address 0x400 + 8*i + 4*w. Word 0 is status/control and word 1 is the buffer address. The pending register is at 0x04, the enable register at 0x08 and the transmit count at 0x20. Read data appears on `bus_rdata` one cycle after the read strobe.
- R3: A write to 0x20 stores min(value, 128, NUM_BD) as the transmit count. The same write returns the transmit pointer to index 0 and the receive pointer to index count, and drops any outstanding transmit request.
- R4: `tx_req_valid` is high when the transmit count is non-zero, no frame is outstanding, and bit 15 (owned) of the descriptor at the transmit pointer is set. The request carries word 1 as the address, bits 31:16 as the length, bit 12 as pad and bit 11 as FCS append. After a request is accepted (`tx_req_valid` and `tx_req_ready` both high), `tx_req_valid` stays low until completion.
- R5: A transmit completion clears bit 15 of the descriptor and writes `tx_status` into bits 8:0. Those bits are: bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun. Bits 31:16 and 14:9 are kept.
- R6: After a descriptor is processed, its direction's pointer returns to the first index of its ring when bit 13 (wrap) of that descriptor is set or the descriptor is the ring's last one. Otherwise the pointer steps by one.
- R7: A frame done on a receive descriptor with bit 15 (free) set rewrites status/control as {length, 0, old bits 14:9, `rx_status`}.
- R8: A frame done when the current receive descriptor is not free, or when there is no receive descriptor, leaves the table and the receive pointer unchanged. It sets pending bit 4 (busy) whatever bit 14 holds.
- R9: On a transmit completion with descriptor bit 14 set, any of status bits 0, 2, 3 or 8 sets pending bit 1; otherwise it sets pending bit 0. With bit 14 clear, no pending bit changes.
- R10: On a stored receive frame with bit 14 set, any of `rx_status` bits 0, 1, 2, 3, 5 or 6 sets pending bit 3; otherwise it sets pending bit 2. With bit 14 clear, no pending bit changes.
- R11: Writing ones to 0x04 clears those pending bits. A set in the same cycle wins over the clear. `irq` is the OR of pending bits ANDed with the enable bits in 0x08.
- R12: A `tx_done` pulse while no frame is outstanding changes no descriptor, pointer or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| tx_req_valid | output | 1 | Transmit descriptor offered to the MAC |
| tx_req_ready | input | 1 | MAC accepts the offered descriptor |
| tx_req_addr | output | 32 | Buffer address of the offered frame |
| tx_req_len | output | 16 | Frame length |
| tx_req_pad | output | 1 | Pad short frame |
| tx_req_crc | output | 1 | Append FCS |
| tx_done | input | 1 | Transmit completion pulse |
| tx_status | input | 9 | Transmit completion status |
| rx_done | input | 1 | Receive frame-done pulse |
| rx_len | input | 16 | Received length |
| rx_status | input | 9 | Receive error/status flags |
| irq | output | 1 | Interrupt request |

## Verification
A register write, a completion and a frame-done all land at the single clock edge that samples them: the descriptor word, the pointer, the pending bits and the count change there. Read data then follows one edge later. `tx_req_valid` and its fields are combinational from the table, so they change at the edge that writes the owned bit or accepts the request. `irq` follows the pending or enable register write at that edge. The bench drives and samples on falling edges only, reads results back through the bus one cycle after each event, and keeps its own model of both pointers across wraps, rewrites of the count and dropped frames.

// File: rtl/eth_bd_pkg.sv
package eth_bd_pkg;

  localparam logic [15:0] BD_BASE  = 16'h0400;
  localparam logic [15:0] OFS_SRC  = 16'h0004;
  localparam logic [15:0] OFS_MASK = 16'h0008;
  localparam logic [15:0] OFS_CNT  = 16'h0020;

  localparam int B_OWN  = 15;
  localparam int B_IRQ  = 14;
  localparam int B_WRAP = 13;
  localparam int B_PAD  = 12;
  localparam int B_CRC  = 11;

  localparam int NSRC = 7;

  // transmit completion counts as an error on carrier loss, late collision,
  // retry exhaustion or underrun
  function automatic logic tx_is_err(input logic [8:0] s);
    return s[0] | s[2] | s[3] | s[8];
  endfunction

  function automatic logic rx_is_err(input logic [8:0] s);
    return s[0] | s[1] | s[2] | s[3] | s[5] | s[6];
  endfunction

  function automatic logic [31:0] tx_close(input logic [31:0] st, input logic [8:0] s);
    return (st & ~32'h0000_81FF) | {23'd0, s};
  endfunction

  function automatic logic [31:0] rx_close(input logic [31:0] st, input logic [15:0] len,
                                           input logic [8:0] s);
    return {len, 1'b0, st[14:9], s};
  endfunction

  // ring step on 8-bit indices (table depth is capped at 128)
  function automatic logic [7:0] ring_step(input logic [7:0] p, input logic [7:0] first,
                                           input logic [7:0] last, input logic wrap);
    return (wrap || p == last) ? first : p + 8'd1;
  endfunction

endpackage

// File: rtl/bd_table.sv
module bd_table #(
  parameter int NUM_BD = 16,
  parameter int IW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [IW-1:0] h_idx,
  input  logic          h_sel,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic [IW-1:0] t_idx,
  output logic [31:0]   t_stat,
  output logic [31:0]   t_addr,
  input  logic          t_we,
  input  logic [31:0]   t_wdata,
  input  logic [IW-1:0] r_idx,
  output logic [31:0]   r_stat,
  input  logic          r_we,
  input  logic [31:0]   r_wdata
);
  logic [31:0] stat_q [NUM_BD];
  logic [31:0] addr_q [NUM_BD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BD; i++) begin
        stat_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      if (h_we) begin
        if (h_sel) addr_q[h_idx] <= h_wdata;
        else       stat_q[h_idx] <= h_wdata;
      end
      // engine writes take precedence over a host write to the same word
      if (t_we) stat_q[t_idx] <= t_wdata;
      if (r_we) stat_q[r_idx] <= r_wdata;
    end
  end

  assign h_rdata = h_sel ? addr_q[h_idx] : stat_q[h_idx];
  assign t_stat  = stat_q[t_idx];
  assign t_addr  = addr_q[t_idx];
  assign r_stat  = stat_q[r_idx];
endmodule

// File: rtl/bd_tx_ring.sv
module bd_tx_ring import eth_bd_pkg::*; #(
  parameter int IW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] cnt,
  input  logic [31:0]   stat,
  input  logic [31:0]   baddr,
  output logic [IW-1:0] ptr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [31:0]   req_addr,
  output logic [15:0]   req_len,
  output logic          req_pad,
  output logic          req_crc,
  input  logic          done,
  input  logic [8:0]    status,
  output logic          wr_en,
  output logic [31:0]   wr_data,
  output logic [1:0]    irq_set
);
  logic busy;
  logic done_ok;
  logic [7:0] nxt;

  assign req_valid = (cnt != '0) && !busy && stat[B_OWN];
  assign req_addr  = baddr;
  assign req_len   = stat[31:16];
  assign req_pad   = stat[B_PAD];
  assign req_crc   = stat[B_CRC];

  assign done_ok = done && busy && !restart;
  assign wr_en   = done_ok;
  assign wr_data = tx_close(stat, status);
  assign irq_set = (done_ok && stat[B_IRQ]) ? (tx_is_err(status) ? 2'b10 : 2'b01) : 2'b00;
  assign nxt     = ring_step(8'(ptr), 8'd0, 8'(cnt) - 8'd1, stat[B_WRAP]);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ptr  <= '0;
      busy <= 1'b0;
    end else if (done_ok) begin
      busy <= 1'b0;
      ptr  <= IW'(nxt);
    end else if (req_valid && req_ready) begin
      busy <= 1'b1;
    end
  end
endmodule

// File: rtl/bd_rx_ring.sv
module bd_rx_ring import eth_bd_pkg::*; #(
  parameter int NUM_BD = 16,
  parameter int IW     = 4,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] first_new,
  input  logic [CW-1:0] cnt,
  input  logic [31:0]   stat,
  output logic [IW-1:0] ptr,
  output logic          slot_empty,
  input  logic          done,
  input  logic [15:0]   len,
  input  logic [8:0]    status,
  output logic          wr_en,
  output logic [31:0]   wr_data,
  output logic [2:0]    irq_set
);
  logic store;
  logic drop;
  logic [7:0] nxt;

  assign slot_empty = (32'(cnt) < NUM_BD) && stat[B_OWN];
  assign store      = done && slot_empty && !restart;
  assign drop       = done && !slot_empty;
  assign wr_en      = store;
  assign wr_data    = rx_close(stat, len, status);
  assign nxt        = ring_step(8'(ptr), 8'(cnt), 8'(NUM_BD - 1), stat[B_WRAP]);

  // {busy, error, frame}
  always_comb begin
    irq_set = 3'b000;
    if (drop) irq_set[2] = 1'b1;
    if (store && stat[B_IRQ]) begin
      if (rx_is_err(status)) irq_set[1] = 1'b1;
      else                   irq_set[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (restart) ptr <= IW'(first_new);
    else if (store)   ptr <= IW'(nxt);
  end
endmodule

// File: rtl/bd_irq_regs.sv
module bd_irq_regs import eth_bd_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] src,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      mask <= '0;
    end else begin
      src <= (src & ~clr) | set;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign irq = |(src & mask);
endmodule

// File: rtl/eth_bd_ring.sv
module eth_bd_ring import eth_bd_pkg::*; #(
  parameter int NUM_BD = 16,
  parameter int AW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tx_req_valid,
  input  logic          tx_req_ready,
  output logic [31:0]   tx_req_addr,
  output logic [15:0]   tx_req_len,
  output logic          tx_req_pad,
  output logic          tx_req_crc,
  input  logic          tx_done,
  input  logic [8:0]    tx_status,
  input  logic          rx_done,
  input  logic [15:0]   rx_len,
  input  logic [8:0]    rx_status,
  output logic          irq
);
  localparam int IW      = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;
  localparam int CW      = $clog2(NUM_BD + 1);
  localparam int CNT_LIM = (NUM_BD < 128) ? NUM_BD : 128;
  localparam int BD_SPAN = NUM_BD * 8;

  function automatic logic [CW-1:0] clamp_cnt(input logic [31:0] v);
    return (v > 32'(CNT_LIM)) ? CW'(CNT_LIM) : CW'(v);
  endfunction

  // bus decode
  logic          wr, rd;
  logic [AW-1:0] bd_off;
  logic          bd_hit;
  logic [IW-1:0] h_idx;
  logic          h_sel;
  logic [31:0]   h_rdata;
  logic          cnt_wr;
  logic [CW-1:0] cnt_new;
  logic [CW-1:0] tx_cnt;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign bd_off  = bus_addr - AW'(BD_BASE);
  assign bd_hit  = (bus_addr >= AW'(BD_BASE)) && (32'(bd_off) < 32'(BD_SPAN));
  assign h_idx   = bd_off[IW+2:3];
  assign h_sel   = bd_off[2];
  assign cnt_wr  = wr && (bus_addr == AW'(OFS_CNT));
  assign cnt_new = clamp_cnt(bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      tx_cnt <= '0;
    else if (cnt_wr) tx_cnt <= cnt_new;
  end

  // engine wires
  logic [IW-1:0]   tx_ptr, rx_ptr;
  logic [31:0]     t_stat, t_addr, r_stat;
  logic            t_we, r_we, rx_slot_empty;
  logic [31:0]     t_wdata, r_wdata;
  logic [1:0]      t_set;
  logic [2:0]      r_set;
  logic [NSRC-1:0] src_set, src_clr, irq_src, irq_mask;

  bd_table #(.NUM_BD(NUM_BD), .IW(IW)) table_i (
    .clk, .rst_n,
    .h_we(wr && bd_hit), .h_idx, .h_sel, .h_wdata(bus_wdata), .h_rdata,
    .t_idx(tx_ptr), .t_stat, .t_addr, .t_we, .t_wdata,
    .r_idx(rx_ptr), .r_stat, .r_we, .r_wdata
  );

  bd_tx_ring #(.IW(IW), .CW(CW)) tx_i (
    .clk, .rst_n, .restart(cnt_wr), .cnt(tx_cnt),
    .stat(t_stat), .baddr(t_addr), .ptr(tx_ptr),
    .req_valid(tx_req_valid), .req_ready(tx_req_ready),
    .req_addr(tx_req_addr), .req_len(tx_req_len),
    .req_pad(tx_req_pad), .req_crc(tx_req_crc),
    .done(tx_done), .status(tx_status),
    .wr_en(t_we), .wr_data(t_wdata), .irq_set(t_set)
  );

  bd_rx_ring #(.NUM_BD(NUM_BD), .IW(IW), .CW(CW)) rx_i (
    .clk, .rst_n, .restart(cnt_wr), .first_new(cnt_new), .cnt(tx_cnt),
    .stat(r_stat), .ptr(rx_ptr), .slot_empty(rx_slot_empty),
    .done(rx_done), .len(rx_len), .status(rx_status),
    .wr_en(r_we), .wr_data(r_wdata), .irq_set(r_set)
  );

  assign src_set = {2'b00, r_set, t_set};
  assign src_clr = (wr && bus_addr == AW'(OFS_SRC)) ? bus_wdata[NSRC-1:0] : '0;

  bd_irq_regs irq_i (
    .clk, .rst_n, .set(src_set), .clr(src_clr),
    .mask_we(wr && bus_addr == AW'(OFS_MASK)), .mask_wdata(bus_wdata[NSRC-1:0]),
    .src(irq_src), .mask(irq_mask), .irq
  );

  // registered read path
  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) begin
      if (bd_hit)                             bus_rdata <= h_rdata;
      else if (bus_addr == AW'(OFS_SRC))  bus_rdata <= 32'(irq_src);
      else if (bus_addr == AW'(OFS_MASK)) bus_rdata <= 32'(irq_mask);
      else if (bus_addr == AW'(OFS_CNT))  bus_rdata <= 32'(tx_cnt);
      else                                    bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/eth_bd_ring_chk.sv
module eth_bd_ring_chk #(
  parameter int NUM_BD = 16,
  parameter int IW     = 4,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_req_valid,
  input logic          tx_req_ready,
  input logic          rx_done,
  input logic          cnt_wr,
  input logic          rx_slot_empty,
  input logic [IW-1:0] tx_ptr,
  input logic [IW-1:0] rx_ptr,
  input logic [CW-1:0] tx_cnt,
  input logic [6:0]    irq_src,
  input logic [6:0]    src_set,
  input logic [6:0]    src_clr
);
  // R4: an accepted request is not offered again in the next cycle
  a_r4_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && tx_req_ready && !cnt_wr) |=> !tx_req_valid);

  // R8: a frame on a non-free slot raises busy
  a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_slot_empty) |=> irq_src[4]);

  // R8: dropped frame leaves the receive pointer in place
  a_r8_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_slot_empty && !cnt_wr) |=> $stable(rx_ptr));

  // R6: transmit pointer stays inside the transmit ring
  a_r6_tx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt != '0) |-> (CW'(tx_ptr) < tx_cnt));

  // R6: receive pointer stays inside the receive ring
  a_r6_rx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) < NUM_BD && !$past(cnt_wr)) |-> (CW'(rx_ptr) >= tx_cnt));

  // R11: clearing every pending bit with nothing to set empties the register
  a_r11_w1c_all: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr == 7'h7F && src_set == 7'h00) |=> (irq_src == 7'h00));
endmodule

bind eth_bd_ring eth_bd_ring_chk #(.NUM_BD(NUM_BD), .IW(IW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
  .rx_done(rx_done), .cnt_wr(cnt_wr), .rx_slot_empty(rx_slot_empty),
  .tx_ptr(tx_ptr), .rx_ptr(rx_ptr), .tx_cnt(tx_cnt),
  .irq_src(irq_src), .src_set(src_set), .src_clr(src_clr)
);

// File: tb/eth_bd_ring_tb_top.sv
module eth_bd_ring_tb_top;
  localparam int NB = 8;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_req_valid, tx_req_ready = 0;
  logic [31:0] tx_req_addr;
  logic [15:0] tx_req_len;
  logic tx_req_pad, tx_req_crc;
  logic tx_done = 0;
  logic [8:0] tx_status = '0;
  logic rx_done = 0;
  logic [15:0] rx_len = '0;
  logic [8:0] rx_status = '0;
  logic irq;

  int total = 0, bad = 0;
  logic [31:0] exp_stat [NB];
  int tptr, rptr, txn;

  always #10 clk = ~clk;

  eth_bd_ring #(.NUM_BD(NB), .AW(AW)) dut_i (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic bw(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic br(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_en = 0;
  endtask

  function automatic int bda(input int i, input int w);
    return 32'h400 + 8 * i + 4 * w;
  endfunction

  task automatic pulse_tx_done(input logic [8:0] s);
    @(negedge clk); tx_done = 1; tx_status = s;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic pulse_rx(input logic [15:0] l, input logic [8:0] s);
    @(negedge clk); rx_done = 1; rx_len = l; rx_status = s;
    @(negedge clk); rx_done = 0;
  endtask

  function automatic logic terr(input logic [8:0] s);
    return s[8] | s[3] | s[2] | s[0];
  endfunction

  function automatic logic rerr(input logic [8:0] s);
    return |(s & 9'h06F);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [8:0] ts [6];
    logic [8:0] rs [3];
    ts[0] = 9'h000; ts[1] = 9'h001; ts[2] = 9'h004;
    ts[3] = 9'h0F2; ts[4] = 9'h100; ts[5] = 9'h008;
    rs[0] = 9'h000; rs[1] = 9'h002; rs[2] = 9'h010;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    check(32'(irq), 0, "R1 irq");
    check(32'(tx_req_valid), 0, "R1 tx_req_valid");
    br(4, d);  check(d, 0, "R1 pending");
    br(8, d);  check(d, 0, "R1 enable");
    br(32, d); check(d, 0, "R1 count");
    for (int i = 0; i < NB; i++)
      for (int w = 0; w < 2; w++) begin
        br(bda(i, w), d); check(d, 0, $sformatf("R1 desc %0d word %0d", i, w));
      end

    // R2: descriptor map write/read sweep (count is 0, nothing is offered)
    for (int i = 0; i < NB; i++)
      for (int w = 0; w < 2; w++)
        bw(bda(i, w), 32'h1357_0000 ^ (i * 32'h0101_0011) ^ (w * 32'h00F0_0F00));
    for (int i = 0; i < NB; i++)
      for (int w = 0; w < 2; w++) begin
        br(bda(i, w), d);
        check(d, 32'h1357_0000 ^ (i * 32'h0101_0011) ^ (w * 32'h00F0_0F00),
              $sformatf("R2 desc %0d word %0d", i, w));
      end
    for (int i = 0; i < NB; i++) begin bw(bda(i, 0), 0); bw(bda(i, 1), 0); end

    // R3: clamp of the count
    bw(32, 32'h100); br(32, d); check(d, NB, "R3 clamp large");
    bw(32, 3);       br(32, d); check(d, 3, "R3 count 3");
    txn = 3; tptr = 0; rptr = 3;

    // transmit sweep over two laps, bit 13 used in the second lap
    for (int k = 0; k < 6; k++) begin
      logic irqen, wrp;
      logic [15:0] ln;
      logic [31:0] st;
      irqen = (k != 4);
      wrp   = (k >= 3) && (tptr == 1);
      ln    = 16'(60 + 7 * k);
      st    = {ln, 1'b1, irqen, wrp, 1'(k >> 1), 1'(k), 11'd0};
      bw(bda(tptr, 1), 32'h1000 + k * 32'h40);
      bw(bda(tptr, 0), st);
      check(32'(tx_req_valid), 1, $sformatf("R4 valid k%0d", k));
      check(tx_req_addr, 32'h1000 + k * 32'h40, $sformatf("R4 addr k%0d", k));
      check(32'(tx_req_len), 32'(ln), $sformatf("R4 len k%0d", k));
      check(32'(tx_req_pad), 32'((k >> 1) & 1), $sformatf("R4 pad k%0d", k));
      check(32'(tx_req_crc), 32'(k & 1), $sformatf("R4 crc k%0d", k));
      @(negedge clk); tx_req_ready = 1;
      @(negedge clk); tx_req_ready = 0;
      check(32'(tx_req_valid), 0, $sformatf("R4 held low k%0d", k));
      pulse_tx_done(ts[k]);
      exp_stat[tptr] = (st & ~32'h0000_81FF) | 32'(ts[k]);
      br(bda(tptr, 0), d);
      check(d, exp_stat[tptr], $sformatf("R5 status word k%0d", k));
      br(4, d);
      check(d, irqen ? (terr(ts[k]) ? 32'h2 : 32'h1) : 32'h0, $sformatf("R9 pending k%0d", k));
      bw(4, 32'h7F);
      tptr = (wrp || tptr == txn - 1) ? 0 : tptr + 1;
    end

    // R12: completion with nothing outstanding
    pulse_tx_done(9'h1FF);
    br(bda(tptr, 0), d); check(d, exp_stat[tptr], "R12 desc untouched");
    br(4, d); check(d, 0, "R12 no pending");
    check(32'(tx_req_valid), 0, "R12 no offer");

    // receive ring 3..7, wrap flag on 5
    for (int i = 3; i < NB; i++) begin
      exp_stat[i] = (i <= 5) ? {16'd0, 1'b1, 1'b1, 1'(i == 5), 13'd0} : 32'd0;
      bw(bda(i, 0), exp_stat[i]);
    end
    for (int k = 0; k < 3; k++) begin
      logic [15:0] ln;
      ln = 16'(100 + 13 * k);
      pulse_rx(ln, rs[k]);
      exp_stat[rptr] = {ln, 1'b0, exp_stat[rptr][14:9], rs[k]};
      br(bda(rptr, 0), d); check(d, exp_stat[rptr], $sformatf("R7 stored k%0d", k));
      br(4, d); check(d, rerr(rs[k]) ? 32'h8 : 32'h4, $sformatf("R10 pending k%0d", k));
      bw(4, 32'h7F);
      rptr = (exp_stat[rptr][13] || rptr == NB - 1) ? txn : rptr + 1;
    end
    check(rptr, 3, "R6 rx wrap model");

    // R8: slot 3 is no longer free
    pulse_rx(16'd55, 9'h000);
    br(bda(3, 0), d); check(d, exp_stat[3], "R8 desc untouched");
    br(4, d); check(d, 32'h10, "R8 busy pending");
    bw(4, 32'h7F);
    bw(bda(3, 0), 32'h0000_8000);
    pulse_rx(16'd77, 9'h040);
    br(bda(3, 0), d); check(d, {16'd77, 7'd0, 9'h040}, "R8 pointer held then R7 store");
    br(4, d); check(d, 0, "R10 no pending without bit14");
    rptr = 4;

    // R11: enable and W1C
    bw(8, 32'h04);
    bw(bda(4, 0), 32'h0000_C000);
    pulse_rx(16'd64, 9'h000);
    check(32'(irq), 1, "R11 irq enabled");
    bw(8, 32'h08);
    check(32'(irq), 0, "R11 irq masked");
    br(8, d); check(d, 32'h08, "R11 enable readback");
    bw(4, 32'h04);
    br(4, d); check(d, 0, "R11 W1C clear");

    // R3/R8: whole table to transmit, receive has no slot
    bw(32, 32'h200); br(32, d); check(d, NB, "R3 clamp to table");
    pulse_rx(16'd10, 9'h000);
    br(4, d); check(d, 32'h10, "R8 busy with no receive ring");
    bw(4, 32'h7F);

    // R3: rewriting the count returns both pointers to their first entries
    bw(32, 3);
    bw(bda(0, 1), 32'h5550);
    bw(bda(0, 0), 32'h0014_8000);
    check(32'(tx_req_valid), 1, "R3 tx pointer at 0");
    check(tx_req_addr, 32'h5550, "R3 tx addr desc0");
    bw(bda(3, 0), 32'h0000_8000);
    pulse_rx(16'd33, 9'h000);
    br(bda(3, 0), d); check(d, {16'd33, 7'd0, 9'h000}, "R3 rx pointer at count");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule